// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache with two ways per set. A byte address from the CPU side is split into three fields, low to high: a byte offset inside the line, a set index, and a tag. Both ways of the indexed set are compared at the same time. The block reports whether the access hit, which way holds the line afterwards, and whether a modified line had to be written out to make room. Each line has a valid flag and a modified flag stored next to its tag. A line is therefore empty, present and clean, or present and modified. One bit per set records which way was used least recently.

The CPU side takes one byte load or byte store at a time. `req_ready` is high only while the block is idle, and every accepted request ends in a single-cycle `resp_valid` pulse. On a miss the block picks a victim way. If that victim is modified, its whole line is first written to the next level. The missing line is then read in over a request/acknowledge memory port that carries whole lines. The access is then replayed against the freshly filled line. Stores that miss allocate the line in the same way. Only modified lines are ever written back.

Top module: `wb_cache2w`

## Requirements
- R1: A byte address splits into offset (low log2(LINE_BYTES) bits), set index (next log2(SETS) bits) and tag (the remaining upper bits). A line fill presents `mem_addr` = {tag, index}, the byte address shifted right by the offset width.
- R2: `resp_hit` is 1 exactly when the addressed line was present and valid in either way of its set when the request was looked up.
- R3: `resp_way` gives the way (0 or 1) that holds the addressed line when the access completes.
- R4: A store hit marks the line modified, and the stored byte goes to the next level only when that line is later evicted. The writeback presents `mem_addr` = {victim tag, index}.
- R5: On a miss, an invalid way is filled before any valid way is evicted. Way 0 is chosen when both ways are invalid. When both ways are valid, the least recently used way is the victim.
- R6: Every hit, and every fill, makes the accessed way the most recently used of its set.
- R7: A miss whose victim is valid and modified first issues a write (`mem_we`=1) of the victim line, then a read of the new line, and reports `resp_wb`=1. A clean or invalid victim is overwritten with no write, and reports `resp_wb`=0. A hit never reports `resp_wb`=1.
- R8: A store miss fetches the line, then writes the byte into it, leaving the line modified.
- R9: Reset empties every line, clears every modified flag and every LRU bit, and leaves `req_ready`=1, `resp_valid`=0 and `mem_req`=0.
- R10: `resp_rdata` returns, for a load, the latest value stored to that byte address (through the cache or the next level) and, for a store, the byte written. Byte k of a line sits in line bits [8k+7:8k].
- R11: While `mem_req` is high and `mem_ack` has not been seen, `mem_req`, `mem_we` and `mem_addr` hold steady.
- R12: `req_ready` is high only when no request is in progress (no memory request or response in that cycle), and `resp_valid` lasts exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Store byte |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Access hit on first lookup |
| resp_way | output | 1 | Way that holds the line |
| resp_wb | output | 1 | A modified victim was written back |
| resp_rdata | output | 8 | Load data, or the stored byte |
| mem_req | output | 1 | Next-level request |
| mem_we | output | 1 | 1 = line writeback, 0 = line fill |
| mem_addr | output | ADDR_W-log2(LINE_BYTES) | Line address |
| mem_wdata | output | 8*LINE_BYTES | Writeback line |
| mem_ack | input | 1 | Next level finished the request |
| mem_rdata | input | 8*LINE_BYTES | Fill line, valid with mem_ack |

## Verification
The hardest case to reach is a writeback of a modified line whose data must later come back correctly. It needs a store hit, then two further misses to the same set so that the LRU bit points at the modified way, and then a reload of the evicted byte from the next level. The stimulus first replays a fixed trace that walks set 0 through fill, second fill and clean eviction. It then drives set 2 and set 1 through store, fill of the empty way, dirty eviction and reload. The bench's line memory stores whatever the writeback carried, so a wrong victim, address or line shows up as wrong reload data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOKUP = 3'd1,
    ST_WBACK  = 3'd2,
    ST_FILL   = 3'd3,
    ST_DONE   = 3'd4
  } wbc_state_e;

  localparam int unsigned NUM_WAYS = 2;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int unsigned SETS  = 4,
  parameter int unsigned TAG_W = 2,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       idx,
  output logic [1:0][TAG_W-1:0]  rd_tag,
  output logic [1:0]             rd_valid,
  output logic [1:0]             rd_dirty,
  output logic                   rd_lru,
  input  logic                   fill_we,
  input  logic                   fill_way,
  input  logic [TAG_W-1:0]       fill_tag,
  input  logic                   dirty_we,
  input  logic                   dirty_way,
  input  logic                   lru_we,
  input  logic                   mru_way
);

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             fill_hit;
    logic             dirty_hit;

    assign fill_hit  = fill_we  && (fill_way  == 1'(w));
    assign dirty_hit = dirty_we && (dirty_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_hit) begin
        vld_q[idx] <= 1'b1;
        drt_q[idx] <= 1'b0;
      end else if (dirty_hit) begin
        drt_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_hit) begin
        tag_q[idx] <= fill_tag;
      end
    end

    assign rd_tag[w]   = tag_q[idx];
    assign rd_valid[w] = vld_q[idx];
    assign rd_dirty[w] = drt_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (lru_we) begin
      lru_q[idx] <= ~mru_way;
    end
  end

  assign rd_lru = lru_q[idx];

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int unsigned SETS       = 4,
  parameter int unsigned LINE_BYTES = 4,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W = 8 * LINE_BYTES
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  output logic [1:0][LINE_W-1:0] rd_line,
  input  logic                   line_we,
  input  logic                   line_way,
  input  logic [LINE_W-1:0]      line_data,
  input  logic                   byte_we,
  input  logic                   byte_way,
  input  logic [OFF_W-1:0]       byte_off,
  input  logic [7:0]             byte_data
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
      if (line_we && (line_way == 1'(w))) begin
        line_q[idx] <= line_data;
      end else if (byte_we && (byte_way == 1'(w))) begin
        line_q[idx][{byte_off, 3'b000} +: 8] <= byte_data;
      end
    end

    assign rd_line[w] = line_q[idx];
  end

endmodule

// File: rtl/wbc_way_select.sv
module wbc_way_select #(
  parameter int unsigned TAG_W = 2
) (
  input  logic [1:0][TAG_W-1:0] tags,
  input  logic [1:0]            valid,
  input  logic [1:0]            dirty,
  input  logic                  lru,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic                  hit_way,
  output logic                  vic_way,
  output logic                  vic_dirty
);

  logic [1:0] match;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == look_tag);
  end

  assign hit     = |match;
  assign hit_way = match[1];

  always_comb begin
    if (!valid[0]) begin
      vic_way = 1'b0;
    end else if (!valid[1]) begin
      vic_way = 1'b1;
    end else begin
      vic_way = lru;
    end
    vic_dirty = valid[vic_way] && dirty[vic_way];
  end

endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w
  import wbc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned LINE_BYTES = 4,
  parameter int unsigned SETS       = 4,
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W   = $clog2(SETS),
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned LADDR_W = ADDR_W - OFF_W,
  localparam int unsigned LINE_W  = 8 * LINE_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [7:0]         req_wdata,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               resp_way,
  output logic               resp_wb,
  output logic [7:0]         resp_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [LINE_W-1:0]  mem_rdata
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_ni = rsync_q[1];

  // request registers
  wbc_state_e        state_q, state_n;
  logic              cap_en;
  logic              op_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  logic [OFF_W-1:0]  a_off;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;

  assign a_off = addr_q[OFF_W-1:0];
  assign a_idx = addr_q[OFF_W +: IDX_W];
  assign a_tag = addr_q[ADDR_W-1 -: TAG_W];

  // array views
  logic [1:0][TAG_W-1:0]  rd_tag;
  logic [1:0]             rd_valid;
  logic [1:0]             rd_dirty;
  logic                   rd_lru;
  logic [1:0][LINE_W-1:0] rd_line;

  logic hit, hit_way, vic_way, vic_dirty;

  // array write controls
  logic fill_we, dirty_we, lru_we, byte_we;

  // per-request status
  logic miss_q, miss_n;
  logic wb_q, wb_n;
  logic vic_q, vic_n;
  logic way_q, way_n;
  logic [7:0] rdata_q, rdata_n;
  logic stat_en;

  wbc_tag_store #(
    .SETS  (SETS),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_ni),
    .idx       (a_idx),
    .rd_tag    (rd_tag),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_lru    (rd_lru),
    .fill_we   (fill_we),
    .fill_way  (vic_q),
    .fill_tag  (a_tag),
    .dirty_we  (dirty_we),
    .dirty_way (hit_way),
    .lru_we    (lru_we),
    .mru_way   (hit_way)
  );

  wbc_data_store #(
    .SETS       (SETS),
    .LINE_BYTES (LINE_BYTES)
  ) u_data (
    .clk       (clk),
    .idx       (a_idx),
    .rd_line   (rd_line),
    .line_we   (fill_we),
    .line_way  (vic_q),
    .line_data (mem_rdata),
    .byte_we   (byte_we),
    .byte_way  (hit_way),
    .byte_off  (a_off),
    .byte_data (wdata_q)
  );

  wbc_way_select #(
    .TAG_W (TAG_W)
  ) u_sel (
    .tags      (rd_tag),
    .valid     (rd_valid),
    .dirty     (rd_dirty),
    .lru       (rd_lru),
    .look_tag  (a_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .vic_way   (vic_way),
    .vic_dirty (vic_dirty)
  );

  // next-state logic
  always_comb begin
    state_n   = state_q;
    cap_en    = 1'b0;
    stat_en   = 1'b0;
    miss_n    = miss_q;
    wb_n      = wb_q;
    vic_n     = vic_q;
    way_n     = way_q;
    rdata_n   = rdata_q;
    fill_we   = 1'b0;
    dirty_we  = 1'b0;
    lru_we    = 1'b0;
    byte_we   = 1'b0;
    req_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {a_tag, a_idx};
    mem_wdata = rd_line[vic_q];

    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          cap_en  = 1'b1;
          stat_en = 1'b1;
          miss_n  = 1'b0;
          wb_n    = 1'b0;
          state_n = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        stat_en = 1'b1;
        if (hit) begin
          lru_we   = 1'b1;
          way_n    = hit_way;
          if (op_wr_q) begin
            byte_we  = 1'b1;
            dirty_we = 1'b1;
            rdata_n  = wdata_q;
          end else begin
            rdata_n  = rd_line[hit_way][{a_off, 3'b000} +: 8];
          end
          state_n = ST_DONE;
        end else begin
          miss_n = 1'b1;
          vic_n  = vic_way;
          if (vic_dirty) begin
            wb_n    = 1'b1;
            state_n = ST_WBACK;
          end else begin
            state_n = ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {rd_tag[vic_q], a_idx};
        if (mem_ack) begin
          state_n = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_we = 1'b1;
          state_n = ST_LOOKUP;
        end
      end
      ST_DONE: begin
        state_n = ST_IDLE;
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      op_wr_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q  <= 1'b0;
      wb_q    <= 1'b0;
      vic_q   <= 1'b0;
      way_q   <= 1'b0;
      rdata_q <= '0;
    end else if (stat_en) begin
      miss_q  <= miss_n;
      wb_q    <= wb_n;
      vic_q   <= vic_n;
      way_q   <= way_n;
      rdata_q <= rdata_n;
    end
  end

  assign resp_valid = (state_q == ST_DONE);
  assign resp_hit   = ~miss_q;
  assign resp_wb    = wb_q;
  assign resp_way   = way_q;
  assign resp_rdata = rdata_q;

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned LINE_BYTES = 4,
  localparam int unsigned LADDR_W = ADDR_W - $clog2(LINE_BYTES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               resp_hit,
  input logic               resp_wb,
  input logic               mem_req,
  input logic               mem_we,
  input logic [LADDR_W-1:0] mem_addr,
  input logic               mem_ack
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R11

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R7

  AST_HIT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !resp_wb); // R7

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R12

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !resp_valid)); // R12

endmodule

bind wb_cache2w wbc_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_wb    (resp_wb),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack)
);

// File: tb/wb_cache2w_test.sv
module wb_cache2w_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [5:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        resp_valid;
  logic        resp_hit;
  logic        resp_way;
  logic        resp_wb;
  logic [7:0]  resp_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [3:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  wb_cache2w uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_way   (resp_way),
    .resp_wb    (resp_wb),
    .resp_rdata (resp_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // next-level memory model: byte i starts as i ^ 8'h5A
  logic [7:0] backing [64];
  logic [3:0] last_fill_addr;
  logic [3:0] last_wb_addr;
  int         wb_seen;

  initial begin
    for (int i = 0; i < 64; i++) backing[i] = 8'(i) ^ 8'h5A;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    wb_seen   = 0;
    last_fill_addr = '0;
    last_wb_addr   = '0;
    forever begin
      int wait_cnt;
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        wait_cnt = 0;
        while (wait_cnt < 2) begin
          @(negedge clk);
          wait_cnt++;
        end
        if (mem_we) begin
          for (int k = 0; k < 4; k++) backing[{mem_addr, 2'(k)}] = mem_wdata[8*k +: 8];
          last_wb_addr = mem_addr;
          wb_seen++;
        end else begin
          for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = backing[{mem_addr, 2'(k)}];
          last_fill_addr = mem_addr;
        end
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  // reference cache state, built from the requirements
  logic [1:0] m_tag [4][2];
  bit         m_v   [4][2];
  bit         m_d   [4][2];
  bit         m_lru [4];
  logic [7:0] shadow [64];

  typedef struct {
    bit         hit;
    bit         way;
    bit         wb;
    logic [7:0] rd;
    logic [3:0] fill_a;
    logic [3:0] wb_a;
    string      name;
  } exp_t;

  exp_t exp_q[$];
  int   resp_cnt = 0;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(resp_hit == e.hit, "R2", {e.name, " hit"}, resp_hit, e.hit);
        check(resp_way == e.way, "R3/R5/R6", {e.name, " way"}, resp_way, e.way);
        check(resp_wb == e.wb, "R7", {e.name, " writeback"}, resp_wb, e.wb);
        check(resp_rdata == e.rd, "R10", {e.name, " data"}, resp_rdata, e.rd);
        if (!e.hit)
          check(last_fill_addr == e.fill_a, "R1", {e.name, " fill addr"},
                last_fill_addr, e.fill_a);
        if (e.wb)
          check(last_wb_addr == e.wb_a, "R4", {e.name, " writeback addr"},
                last_wb_addr, e.wb_a);
      end
      resp_cnt++;
    end
  end

  task automatic access(input bit wr, input logic [5:0] a, input logic [7:0] d,
                        input string name);
    exp_t e;
    int   idx;
    logic [1:0] tg;
    bit   w;
    int   start;
    idx = int'(a[3:2]);
    tg  = a[5:4];
    e.name   = name;
    e.wb     = 1'b0;
    e.fill_a = a[5:2];
    e.wb_a   = '0;
    if (m_v[idx][0] && m_tag[idx][0] == tg) begin
      e.hit = 1'b1; w = 1'b0;
    end else if (m_v[idx][1] && m_tag[idx][1] == tg) begin
      e.hit = 1'b1; w = 1'b1;
    end else begin
      e.hit = 1'b0;
      if (!m_v[idx][0])      w = 1'b0;
      else if (!m_v[idx][1]) w = 1'b1;
      else                   w = m_lru[idx];
      if (m_v[idx][w] && m_d[idx][w]) begin
        e.wb   = 1'b1;
        e.wb_a = {m_tag[idx][w], a[3:2]};
      end
      m_v[idx][w]   = 1'b1;
      m_d[idx][w]   = 1'b0;
      m_tag[idx][w] = tg;
    end
    m_lru[idx] = ~w;
    e.way = w;
    if (wr) begin
      m_d[idx][w] = 1'b1;
      shadow[a]   = d;
    end
    e.rd = shadow[a];
    exp_q.push_back(e);

    start = resp_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (resp_cnt == start) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R12", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; m_tag[s][w] = '0;
      end
    end
    for (int i = 0; i < 64; i++) shadow[i] = 8'(i) ^ 8'h5A;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: idle outputs after reset
    check(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);
    check(resp_valid == 1'b0, "R9", "resp_valid after reset", resp_valid, 0);
    check(mem_req == 1'b0, "R9", "mem_req after reset", mem_req, 0);

    // fixed trace: R2 R3 R5 R6 (set 0 fills way 0, way 1, then evicts way 0)
    access(1'b0, 6'h2A, 8'h00, "ld 2A");
    access(1'b0, 6'h2B, 8'h00, "ld 2B");
    access(1'b0, 6'h3C, 8'h00, "ld 3C");
    access(1'b0, 6'h20, 8'h00, "ld 20");
    access(1'b0, 6'h33, 8'h00, "ld 33");
    access(1'b0, 6'h11, 8'h00, "ld 11");
    access(1'b1, 6'h29, 8'hC3, "st 29");   // R4 store hit marks line modified

    // set 2: empty way filled first, then dirty eviction and reload (R4 R7)
    access(1'b0, 6'h0A, 8'h00, "ld 0A");
    access(1'b0, 6'h1A, 8'h00, "ld 1A");
    access(1'b0, 6'h29, 8'h00, "ld 29 reload");

    // set 1: store miss allocates and leaves line modified (R8)
    access(1'b1, 6'h05, 8'h77, "st 05 miss");
    access(1'b0, 6'h05, 8'h00, "ld 05");
    access(1'b1, 6'h06, 8'h11, "st 06");
    access(1'b0, 6'h15, 8'h00, "ld 15");
    access(1'b0, 6'h25, 8'h00, "ld 25 evict dirty");
    access(1'b0, 6'h05, 8'h00, "ld 05 reload");
    access(1'b0, 6'h06, 8'h00, "ld 06");

    // R7: two dirty evictions in total reached the next level
    repeat (2) @(negedge clk);
    check(wb_seen == 2, "R7", "writeback count", wb_seen, 2);
    check(exp_q.size() == 0, "R12", "responses outstanding", exp_q.size(), 0);
    finish_run();
  end

endmodule